// File: doc/BRIEF.md
# Digital soft-start and fault supervisor

This block sequences the start-up of a synchronous buck converter and guards it against faults. It runs on the switching-oscillator clock. It watches four flags: supply good, enable, over-current and under-voltage. It drives three things: a stepped reference code for the regulation loop's DAC, a run enable for the gate drivers, and a latched-off indication.

Once supply and enable are both true, the block waits a fixed start-up delay. It then raises the reference code from zero in equal timed steps until full scale, and holds it there. An over-current while the converter runs shuts the converter down and restarts the whole start sequence. The over-current count survives enable cycling, and reaching the count limit latches the converter off. An under-voltage seen once the ramp has finished latches it off at once. The latch, and the over-current count, are cleared only by the supply-good flag going low.

Top module: `ss_fault_sup`

## Requirements
- R1: While reset is asserted, and after its release with all flags low, `run_en`, `latched_off` and `ref_code` are all 0.
- R2: A start needs `supply_ok` and `enable` both high. Either one alone leaves every output at 0.
- R3: Take the clock edge that first samples both start conditions as edge 0. For the next `DELAY_CYC` edges, `run_en` and `ref_code` stay 0. `run_en` becomes 1 after edge `DELAY_CYC`.
- R4: Counting t edges from edge 0, with t >= `DELAY_CYC`, `ref_code` is the binary value min((t-`DELAY_CYC`)/`STEP_CYC`, `FULL_CODE`). The code rises by exactly one every `STEP_CYC` cycles, reaches `FULL_CODE` after `FULL_CODE*STEP_CYC` cycles of ramp, and then holds.
- R5: `enable` low while not latched forces `run_en` and `ref_code` to 0 after the next edge. Raising it again restarts from R3.
- R6: `oc_flag` sampled high while `run_en` is 1, with the over-current count below `OC_LIMIT-1`, forces `run_en` and `ref_code` to 0 after that edge. That edge then serves as edge 0 of a fresh R3/R4 sequence.
- R7: The over-current event that brings the count to `OC_LIMIT` (2 by default) sets `latched_off` to 1 after that edge, with `run_en` 0 and `ref_code` 0.
- R8: `uv_flag` is ignored during the delay and the ramp. Sampled high once `ref_code` has reached `FULL_CODE`, it sets `latched_off` after that edge.
- R9: Once latched, the outputs stay at `latched_off`=1, `run_en`=0, `ref_code`=0 whatever `enable`, `oc_flag` or `uv_flag` do. `supply_ok` low clears the latch and the over-current count after the next edge.
- R10: A disable/enable cycle does not clear the over-current count. One over-current, a disable, a re-enable and a second over-current latch the block.
- R11: `oc_flag` has no effect while `run_en` is 0 (idle or delay phase), and such an event is not counted.
- R12: `supply_ok` low at any time forces every output to 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching-oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above its power-on threshold |
| enable | input | 1 | Converter enable (compensation node not pulled low) |
| oc_flag | input | 1 | Over-current comparator output |
| uv_flag | input | 1 | Feedback-below-half-reference comparator output |
| ref_code | output | CODE_W (7 by default) | Stepped reference code, `FULL_CODE` is the full reference |
| run_en | output | 1 | Converter run enable for the gate drivers |
| latched_off | output | 1 | Fault latch: both gates off until supply power-on reset |

## Verification
The bench builds the block with a 6-cycle delay, 4-cycle steps, a full scale of 8 and an over-current limit of 2, so one whole start sequence is only 38 cycles long. At that size the bench can inject an over-current, an under-voltage or an enable drop at every cycle offset of the delay, the ramp and the first hold cycles. It then follows each full restart or latch and checks every output on every cycle against the arithmetic model. It also walks through the latch-release path and the count's survival across an enable cycle.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_RAMP = 3'd2,
    ST_HOLD = 3'd3,
    ST_TRIP = 3'd4
  } ssf_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ssf_rst_sync.sv
module ssf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/ssf_delay_timer.sv
module ssf_delay_timer #(
  parameter int unsigned DELAY_CYC = 480
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = ssf_pkg::cnt_width(DELAY_CYC);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | run;
    if (clr)               cnt_d = '0;
    else if (cnt_q < LAST) cnt_d = cnt_q + 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = run & (cnt_q == LAST);
endmodule

// File: rtl/ssf_ramp_gen.sv
module ssf_ramp_gen #(
  parameter int unsigned STEP_CYC  = 8,
  parameter int unsigned FULL_CODE = 64,
  parameter int unsigned CODE_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  output logic [CODE_W-1:0] code,
  output logic              last_step
);
  localparam int unsigned SW = ssf_pkg::cnt_width(STEP_CYC);
  localparam logic [SW-1:0]     STEP_LAST = SW'(STEP_CYC - 1);
  localparam logic [CODE_W-1:0] CODE_TOP  = CODE_W'(FULL_CODE);
  localparam logic [CODE_W-1:0] CODE_PRE  = CODE_W'(FULL_CODE - 1);

  logic [SW-1:0]     step_q, step_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              tick, upd_en;

  always_comb begin
    tick   = run & (step_q == STEP_LAST);
    upd_en = clr | run;
    step_d = step_q;
    code_d = code_q;
    if (clr) begin
      step_d = '0;
      code_d = '0;
    end else if (tick) begin
      step_d = '0;
      if (code_q < CODE_TOP) code_d = code_q + 1'b1;
    end else begin
      step_d = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      code_q <= '0;
    end else if (upd_en) begin
      step_q <= step_d;
      code_q <= code_d;
    end
  end

  assign code      = code_q;
  assign last_step = tick & (code_q == CODE_PRE);
endmodule

// File: rtl/ssf_trip_count.sv
module ssf_trip_count #(
  parameter int unsigned OC_LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por,
  input  logic bump,
  output logic at_last
);
  localparam int unsigned CW = ssf_pkg::cnt_width(OC_LIMIT + 1);
  localparam logic [CW-1:0] TOP  = CW'(OC_LIMIT);
  localparam logic [CW-1:0] LAST = CW'(OC_LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = por | bump;
    if (por)               cnt_d = '0;
    else if (cnt_q < TOP)  cnt_d = cnt_q + 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_last = (cnt_q >= LAST);
endmodule

// File: rtl/ss_fault_sup.sv
module ss_fault_sup
  import ssf_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 480,
  parameter int unsigned STEP_CYC  = 8,
  parameter int unsigned FULL_CODE = 64,
  parameter int unsigned OC_LIMIT  = 2,
  localparam int unsigned CODE_W   = $clog2(FULL_CODE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              enable,
  input  logic              oc_flag,
  input  logic              uv_flag,
  output logic [CODE_W-1:0] ref_code,
  output logic              run_en,
  output logic              latched_off
);
  logic       rst_i_n;
  ssf_state_e state_q, state_d;
  logic       dly_done, ramp_last, oc_at_last, oc_bump;
  logic       dly_clr, dly_run, ramp_clr, ramp_run;

  ssf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Next-state: power-on reset first, then the latch, then enable,
  // then faults while running, then normal sequencing.
  always_comb begin
    state_d = state_q;
    oc_bump = 1'b0;
    if (!supply_ok) begin
      state_d = ST_IDLE;
    end else if (state_q == ST_TRIP) begin
      state_d = ST_TRIP;
    end else if (!enable) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: state_d = ST_WAIT;
        ST_WAIT: if (dly_done) state_d = ST_RAMP;
        ST_RAMP, ST_HOLD: begin
          if (oc_flag) begin
            oc_bump = 1'b1;
            state_d = oc_at_last ? ST_TRIP : ST_WAIT;
          end else if (uv_flag && (state_q == ST_HOLD)) begin
            state_d = ST_TRIP;
          end else if ((state_q == ST_RAMP) && ramp_last) begin
            state_d = ST_HOLD;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_comb begin
    dly_run  = (state_q == ST_WAIT);
    dly_clr  = (state_q != ST_WAIT);
    ramp_run = (state_q == ST_RAMP);
    ramp_clr = !((state_d == ST_RAMP) || (state_d == ST_HOLD));
  end

  ssf_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_dly (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (dly_clr),
    .run   (dly_run),
    .done  (dly_done)
  );

  ssf_ramp_gen #(
    .STEP_CYC  (STEP_CYC),
    .FULL_CODE (FULL_CODE),
    .CODE_W    (CODE_W)
  ) u_ramp (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .clr       (ramp_clr),
    .run       (ramp_run),
    .code      (ref_code),
    .last_step (ramp_last)
  );

  ssf_trip_count #(.OC_LIMIT(OC_LIMIT)) u_trip (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .por     (!supply_ok),
    .bump    (oc_bump),
    .at_last (oc_at_last)
  );

  assign run_en      = (state_q == ST_RAMP) || (state_q == ST_HOLD);
  assign latched_off = (state_q == ST_TRIP);
endmodule

// File: rtl/ss_fault_sup_chk.sv
module ss_fault_sup_chk #(
  parameter int unsigned FULL_CODE = 64,
  localparam int unsigned CODE_W   = $clog2(FULL_CODE + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_ok,
  input logic              enable,
  input logic              oc_flag,
  input logic              uv_flag,
  input logic [CODE_W-1:0] ref_code,
  input logic              run_en,
  input logic              latched_off
);
  localparam logic [CODE_W-1:0] TOP = CODE_W'(FULL_CODE);

  // R4
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_code <= TOP);

  // R4
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ref_code == $past(ref_code)) ||
             (ref_code == $past(ref_code) + 1'b1) || (ref_code == '0));

  // R5
  enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !run_en && (ref_code == '0));

  // R6
  oc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && oc_flag) |=> !run_en && (ref_code == '0));

  // R8
  uv_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && enable && supply_ok && !oc_flag && uv_flag && (ref_code == TOP))
      |=> latched_off);

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_off && supply_ok) |=> latched_off);

  // R9
  latch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off |-> !run_en && (ref_code == '0));

  // R12
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !run_en && !latched_off && (ref_code == '0));
endmodule

bind ss_fault_sup ss_fault_sup_chk #(.FULL_CODE(FULL_CODE)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_ok   (supply_ok),
  .enable      (enable),
  .oc_flag     (oc_flag),
  .uv_flag     (uv_flag),
  .ref_code    (ref_code),
  .run_en      (run_en),
  .latched_off (latched_off)
);

// File: tb/test_ss_fault_sup.sv
module test_ss_fault_sup;
  localparam int D  = 6;
  localparam int S  = 4;
  localparam int F  = 8;
  localparam int L  = 2;
  localparam int CW = $clog2(F + 1);
  localparam int RAMP_END = D + F * S;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, enable = 1'b0, oc_flag = 1'b0, uv_flag = 1'b0;
  logic [CW-1:0] ref_code;
  logic run_en, latched_off;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ss_fault_sup #(.DELAY_CYC(D), .STEP_CYC(S), .FULL_CODE(F), .OC_LIMIT(L)) i_ss_fault_sup (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
    .oc_flag(oc_flag), .uv_flag(uv_flag), .ref_code(ref_code),
    .run_en(run_en), .latched_off(latched_off)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic er, input int ec, input logic el);
    n_run++;
    if (run_en !== er || int'(ref_code) != ec || latched_off !== el) begin
      n_fail++;
      $display("FAIL %s: run=%0b code=%0d lat=%0b, expected run=%0b code=%0d lat=%0b",
               req, run_en, ref_code, latched_off, er, ec, el);
    end
  endtask

  function automatic logic exp_run(input int t);
    return t >= D;
  endfunction

  function automatic int exp_code(input int t);
    int k;
    if (t < D) return 0;
    k = (t - D) / S;
    return (k > F) ? F : k;
  endfunction

  // R12: supply low clears everything; used as power-on reset between cases
  task automatic por();
    supply_ok = 1'b0; enable = 1'b0; oc_flag = 1'b0; uv_flag = 1'b0;
    cyc();
    chk("R12", 1'b0, 0, 1'b0);
  endtask

  task automatic start();
    supply_ok = 1'b1; enable = 1'b1;
  endtask

  // R3 / R4: one check per cycle of the start sequence
  task automatic run_to(input int from, input int to, input string req);
    for (int t = from; t <= to; t++) begin
      cyc();
      chk(req, exp_run(t), exp_code(t), 1'b0);
    end
  endtask

  task automatic pulse_oc();
    oc_flag = 1'b1; cyc(); oc_flag = 1'b0;
  endtask

  initial begin
    cyc(); cyc();
    chk("R1", 1'b0, 0, 1'b0);
    rst_n = 1'b1;
    repeat (3) begin cyc(); chk("R1", 1'b0, 0, 1'b0); end

    // R2: either start condition alone does nothing
    supply_ok = 1'b1; enable = 1'b0;
    repeat (D + 3) begin cyc(); chk("R2", 1'b0, 0, 1'b0); end
    supply_ok = 1'b0; enable = 1'b1;
    repeat (D + 3) begin cyc(); chk("R2", 1'b0, 0, 1'b0); end

    // R3 R4 R6 R7 R11: first over-current at every offset
    for (int o = 0; o <= RAMP_END + 2; o++) begin
      por(); start();
      run_to(0, o, "R3/R4");
      pulse_oc();
      if (o >= D) begin
        chk("R6", 1'b0, 0, 1'b0);
        run_to(1, RAMP_END + 1, "R6");
        pulse_oc();
        chk("R7", 1'b0, 0, 1'b1);
      end else begin
        chk("R11", exp_run(o + 1), exp_code(o + 1), 1'b0);
        run_to(o + 2, RAMP_END + 1, "R11");
        pulse_oc();
        chk("R11", 1'b0, 0, 1'b0);
      end
    end

    // R8: under-voltage at every offset
    for (int o = 0; o <= RAMP_END + 2; o++) begin
      por(); start();
      run_to(0, o, "R4");
      uv_flag = 1'b1; cyc(); uv_flag = 1'b0;
      if (o >= RAMP_END) chk("R8", 1'b0, 0, 1'b1);
      else begin
        chk("R8", exp_run(o + 1), exp_code(o + 1), 1'b0);
        run_to(o + 2, RAMP_END + 1, "R8");
      end
    end

    // R5: enable drop at every offset, then full restart
    for (int o = 0; o <= RAMP_END + 1; o++) begin
      por(); start();
      run_to(0, o, "R4");
      enable = 1'b0; cyc(); chk("R5", 1'b0, 0, 1'b0);
      cyc(); chk("R5", 1'b0, 0, 1'b0);
      enable = 1'b1;
      run_to(0, RAMP_END + 1, "R5");
    end

    // R9: latch holds against all flags, supply low releases and clears count
    por(); start();
    run_to(0, RAMP_END, "R4");
    uv_flag = 1'b1; cyc(); uv_flag = 1'b0;
    chk("R9", 1'b0, 0, 1'b1);
    enable = 1'b0; cyc(); chk("R9", 1'b0, 0, 1'b1);
    enable = 1'b1; cyc(); chk("R9", 1'b0, 0, 1'b1);
    oc_flag = 1'b1; uv_flag = 1'b1;
    repeat (RAMP_END + 2) begin cyc(); chk("R9", 1'b0, 0, 1'b1); end
    oc_flag = 1'b0; uv_flag = 1'b0;
    supply_ok = 1'b0; enable = 1'b0;
    cyc(); chk("R9", 1'b0, 0, 1'b0);
    start();
    run_to(0, RAMP_END + 1, "R9");
    pulse_oc();
    chk("R9", 1'b0, 0, 1'b0);

    // R10: count survives enable cycling
    por(); start();
    run_to(0, D + 2, "R4");
    pulse_oc();
    chk("R10", 1'b0, 0, 1'b0);
    enable = 1'b0; cyc(); chk("R10", 1'b0, 0, 1'b0);
    enable = 1'b1;
    run_to(0, RAMP_END + 1, "R10");
    pulse_oc();
    chk("R10", 1'b0, 0, 1'b1);

    // R12: supply loss in mid-ramp
    por(); start();
    run_to(0, D + 5, "R4");
    supply_ok = 1'b0;
    cyc(); chk("R12", 1'b0, 0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all R): finished=0, expected finished=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule